// File: doc/BRIEF.md
# 256-Byte Hamming Check-Code Engine

This block builds a 24-bit single-error-correcting check code over a 256-byte chunk. The bytes arrive one per cycle, each with a valid strobe and its own byte index. Six of the code bits are column parities, taken over chosen bit positions of every byte. Sixteen are row parities, taken over whole-byte parities grouped by the bits of the byte index. The top two bits are fixed at one. A 512-byte page uses the engine twice, once for each half.

When the last byte of a chunk has been taken in, the engine XORs the code it has built with a stored code from the caller. It then sorts the outcome by the number of set bits in that syndrome. Zero set bits means the data is clean. Eleven set bits means one data bit flipped; the engine reports which byte and which bit, and the caller applies the fix. One set bit means the stored code itself was damaged and the data is good. Any other count is uncorrectable.

A control state machine has three states. S_IDLE waits and ignores bytes. S_ACCUM gathers bytes. S_REPORT presents the result for a single cycle. The transitions are: START (chunk_start from any state, to S_ACCUM), LAST_BYTE (the 256th accepted byte, S_ACCUM to S_REPORT) and RETIRE (S_REPORT to S_IDLE, always taken).

Top module: `ecc256_engine`

## Requirements
- R1: After reset, res_valid is 0 and code_out is 24'hC00000.
- R2: chunk_start clears the parity accumulators and the byte count in any state. In the cycle after it, code_out is 24'hC00000, and bytes taken in before it have no effect on the next result. A byte offered in the same cycle as chunk_start is dropped.
- R3: code_out[16+2j+1] is the XOR over all accepted bytes of the data bits whose position has bit j set, and code_out[16+2j] is the XOR of those whose position has bit j clear, for j = 0..2.
- R4: code_out[2k+1] is the XOR of the byte parities of accepted bytes whose in_idx has bit k set, and code_out[2k] is the XOR for those with bit k clear, for k = 0..7.
- R5: code_out[23:22] are always 2'b11.
- R6: res_valid is high for exactly one cycle. That cycle is the one after the clock edge that accepts the 256th valid byte since chunk_start. Cycles with in_valid low are not counted.
- R7: When the syndrome (stored_code XOR code_out) is all zero, res_status is 2'd0 (clean).
- R8: When the syndrome has exactly 11 bits set, res_status is 2'd1 (correctable). err_byte then collects syndrome bits 15,13,...,1 as bits 7..0, and err_bit collects syndrome bits 21,19,17 as bits 2..0.
- R9: When the syndrome has exactly one bit set, res_status is 2'd2 (stored code damaged). This includes a flipped fixed bit.
- R10: Any other syndrome weight gives res_status 2'd3 (uncorrectable).
- R11: In S_IDLE, valid bytes are ignored: code_out holds and res_valid stays 0.
- R12: err_byte and err_bit are zero unless res_status is 2'd1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chunk_start | input | 1 | Clears accumulators and begins a chunk |
| in_valid | input | 1 | in_byte and in_idx hold a byte to take in |
| in_byte | input | 8 | Data byte |
| in_idx | input | 8 | Position of the byte within the chunk |
| stored_code | input | 24 | Previously saved code, compared during S_REPORT |
| code_out | output | 24 | Running code: {2'b11, column parity, row parity} |
| res_valid | output | 1 | One-cycle strobe marking the result |
| res_status | output | 2 | 0 clean, 1 correctable, 2 code damaged, 3 uncorrectable |
| err_byte | output | 8 | Offset of the flipped byte when correctable |
| err_bit | output | 3 | Bit position of the flipped bit when correctable |

## Verification
code_out reflects a byte at the first falling edge after the rising edge that accepted it. It is all zero apart from the fixed bits one edge after chunk_start. res_valid, res_status, err_byte and err_bit are due at the falling edge that directly follows the edge taking the 256th valid byte. The bench drives and samples only on falling edges. It checks res_valid is still low just before that last edge, reads the classification in that one cycle, and checks the strobe has dropped one cycle later. Gapped streams and a restart partway through a chunk show the count follows accepted bytes, not clock cycles.

// File: rtl/ecc256_pkg.sv
package ecc256_pkg;

    typedef enum logic [1:0] {
        ECC_CLEAN    = 2'd0,
        ECC_FIX      = 2'd1,
        ECC_CODE_ERR = 2'd2,
        ECC_FATAL    = 2'd3
    } ecc_status_e;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ACCUM  = 2'd1,
        S_REPORT = 2'd2
    } ecc_fsm_e;

endpackage

// File: rtl/ecc256_byte_terms.sv
module ecc256_byte_terms #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8
) (
    input  logic [DATA_W-1:0]          din,
    input  logic [IDX_W-1:0]           idx,
    output logic [2*$clog2(DATA_W)-1:0] col_terms,
    output logic [2*IDX_W-1:0]         row_terms
);
    localparam int COL_PAIRS = $clog2(DATA_W);

    logic byte_par;
    assign byte_par = ^din;

    // Column pairs: odd member takes bit positions with index bit j set
    for (genvar j = 0; j < COL_PAIRS; j++) begin : g_col
        always_comb begin
            col_terms[2*j+1] = 1'b0;
            col_terms[2*j]   = 1'b0;
            for (int i = 0; i < DATA_W; i++) begin
                if (((i >> j) & 1) == 1)
                    col_terms[2*j+1] = col_terms[2*j+1] ^ din[i];
                else
                    col_terms[2*j]   = col_terms[2*j] ^ din[i];
            end
        end
    end

    // Row pairs: byte parity steered by each bit of the byte index
    for (genvar k = 0; k < IDX_W; k++) begin : g_row
        assign row_terms[2*k+1] = idx[k] & byte_par;
        assign row_terms[2*k]   = ~idx[k] & byte_par;
    end

endmodule

// File: rtl/ecc256_syndrome_class.sv
module ecc256_syndrome_class
    import ecc256_pkg::*;
#(
    parameter int COL_PAIRS = 3,
    parameter int IDX_W     = 8,
    parameter int CODE_W    = 24
) (
    input  logic [CODE_W-1:0]    syndrome,
    output ecc_status_e          status,
    output logic [IDX_W-1:0]     loc_byte,
    output logic [COL_PAIRS-1:0] loc_bit
);
    localparam int ROW_W   = 2 * IDX_W;
    localparam int FIX_WT  = COL_PAIRS + IDX_W;

    int weight;
    logic [IDX_W-1:0]     odd_rows;
    logic [COL_PAIRS-1:0] odd_cols;

    for (genvar k = 0; k < IDX_W; k++) begin : g_rsel
        assign odd_rows[k] = syndrome[2*k+1];
    end
    for (genvar j = 0; j < COL_PAIRS; j++) begin : g_csel
        assign odd_cols[j] = syndrome[ROW_W + 2*j + 1];
    end

    always_comb begin
        weight   = $countones(syndrome);
        loc_byte = '0;
        loc_bit  = '0;
        if (weight == 0) begin
            status = ECC_CLEAN;
        end else if (weight == FIX_WT) begin
            status   = ECC_FIX;
            loc_byte = odd_rows;
            loc_bit  = odd_cols;
        end else if (weight == 1) begin
            status = ECC_CODE_ERR;
        end else begin
            status = ECC_FATAL;
        end
    end

endmodule

// File: rtl/ecc256_engine.sv
module ecc256_engine
    import ecc256_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CHUNK_BYTES = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        chunk_start,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic [7:0]  in_idx,
    input  logic [23:0] stored_code,
    output logic [23:0] code_out,
    output logic        res_valid,
    output logic [1:0]  res_status,
    output logic [7:0]  err_byte,
    output logic [2:0]  err_bit
);
    localparam int IDX_W     = $clog2(CHUNK_BYTES);
    localparam int COL_PAIRS = $clog2(DATA_W);
    localparam int COL_W     = 2 * COL_PAIRS;
    localparam int ROW_W     = 2 * IDX_W;
    localparam int PAR_W     = COL_W + ROW_W;
    localparam int CODE_W    = ((PAR_W + 7) / 8) * 8;
    localparam int PAD_W     = CODE_W - PAR_W;
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CHUNK_BYTES - 1);
    localparam logic [CODE_W-1:0] CLR_CODE  = {{PAD_W{1'b1}}, {PAR_W{1'b0}}};

    ecc_fsm_e state, state_nx;
    logic [COL_W-1:0] col_acc;
    logic [ROW_W-1:0] row_acc;
    logic [IDX_W-1:0] cnt;
    logic [COL_W-1:0] col_terms;
    logic [ROW_W-1:0] row_terms;
    logic             take;
    ecc_status_e      cls_status;
    logic [IDX_W-1:0]     cls_byte;
    logic [COL_PAIRS-1:0] cls_bit;

    ecc256_byte_terms #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_terms (
        .din       (in_byte),
        .idx       (in_idx),
        .col_terms (col_terms),
        .row_terms (row_terms)
    );

    ecc256_syndrome_class #(.COL_PAIRS(COL_PAIRS), .IDX_W(IDX_W), .CODE_W(CODE_W)) u_class (
        .syndrome (stored_code ^ code_out),
        .status   (cls_status),
        .loc_byte (cls_byte),
        .loc_bit  (cls_bit)
    );

    assign take = (state == S_ACCUM) && in_valid && !chunk_start;

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   state_nx = S_IDLE;
            S_ACCUM:  if (take && cnt == LAST_IDX) state_nx = S_REPORT;
            S_REPORT: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
        if (chunk_start) state_nx = S_ACCUM;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Accumulators and byte count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_acc <= '0;
            row_acc <= '0;
            cnt     <= '0;
        end else if (chunk_start) begin
            col_acc <= '0;
            row_acc <= '0;
            cnt     <= '0;
        end else if (take) begin
            col_acc <= col_acc ^ col_terms;
            row_acc <= row_acc ^ row_terms;
            cnt     <= cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        code_out   = {{PAD_W{1'b1}}, col_acc, row_acc};
        res_valid  = 1'b0;
        res_status = ECC_CLEAN;
        err_byte   = '0;
        err_bit    = '0;
        unique case (state)
            S_IDLE, S_ACCUM: ;
            S_REPORT: begin
                res_valid  = 1'b1;
                res_status = cls_status;
                err_byte   = cls_byte;
                err_bit    = cls_bit;
            end
            default: ;
        endcase
    end

    // R6
    res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R6
    res_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(in_valid));

    // R2
    clear_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(chunk_start) |-> code_out == CLR_CODE);

    // R7
    clean_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_status == ECC_CLEAN) |-> code_out == stored_code);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !chunk_start) |=> $stable(code_out));

endmodule

// File: tb/tb_ecc256_engine.sv
module tb_ecc256_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        chunk_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic [7:0]  in_idx = '0;
    logic [23:0] stored_code = '0;
    logic [23:0] code_out;
    logic        res_valid;
    logic [1:0]  res_status;
    logic [7:0]  err_byte;
    logic [2:0]  err_bit;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] buf_data [256];

    always #4 clk = ~clk;

    ecc256_engine dut (
        .clk(clk), .rst_n(rst_n), .chunk_start(chunk_start),
        .in_valid(in_valid), .in_byte(in_byte), .in_idx(in_idx),
        .stored_code(stored_code), .code_out(code_out),
        .res_valid(res_valid), .res_status(res_status),
        .err_byte(err_byte), .err_bit(err_bit)
    );

    // {seed, mode, flip byte, flip bit, gaps}; mode 0 clean, 1 data flip, 2 code flip, 3 double data flip
    localparam logic [31:0] VEC [9] = '{
        {8'h3C, 4'd0, 8'd0,   5'd0,  7'd0},
        {8'hA5, 4'd1, 8'd0,   5'd0,  7'd0},
        {8'h17, 4'd1, 8'd255, 5'd7,  7'd0},
        {8'h6E, 4'd1, 8'h93,  5'd4,  7'd1},
        {8'h21, 4'd2, 8'd0,   5'd5,  7'd0},
        {8'hD2, 4'd2, 8'd0,   5'd20, 7'd0},
        {8'h5F, 4'd2, 8'd0,   5'd23, 7'd0},
        {8'h4B, 4'd3, 8'h10,  5'd3,  7'd0},
        {8'h88, 4'd0, 8'd0,   5'd0,  7'd1}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_code();
        logic [5:0]  col = '0;
        logic [15:0] row = '0;
        for (int i = 0; i < 256; i++) begin
            for (int p = 0; p < 8; p++) begin
                if (buf_data[i][p]) begin
                    for (int j = 0; j < 3; j++) begin
                        if (p[j]) col[2*j+1] = ~col[2*j+1];
                        else      col[2*j]   = ~col[2*j];
                    end
                    for (int k = 0; k < 8; k++) begin
                        if (i[k]) row[2*k+1] = ~row[2*k+1];
                        else      row[2*k]   = ~row[2*k];
                    end
                end
            end
        end
        return {2'b11, col, row};
    endfunction

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < 256; i++)
            buf_data[i] = (8'(i) * seed) ^ (8'(i >> 3) + seed);
    endtask

    // Start a chunk and stream buf_data; leaves time at the result cycle
    task automatic stream(input bit gaps);
        chunk_start = 1'b1;
        @(negedge clk);
        chunk_start = 1'b0;
        chk(code_out == 24'hC00000, "R2 cleared code", code_out, 24'hC00000);
        for (int i = 0; i < 256; i++) begin
            if (gaps && (i % 16) == 15) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_byte  = buf_data[i];
            in_idx   = 8'(i);
            if (i == 255) chk(res_valid == 1'b0, "R6 no early result", res_valid, 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    task automatic run_vec(input logic [31:0] v);
        logic [7:0]  seed  = v[31:24];
        logic [3:0]  mode  = v[23:20];
        logic [7:0]  fbyte = v[19:12];
        logic [4:0]  fbit  = v[11:7];
        logic [23:0] good, fed;
        logic [1:0]  exp_st;
        fill(seed);
        good = ref_code();
        stored_code = good;
        exp_st = 2'd0;
        if (mode == 1) begin
            buf_data[fbyte][fbit[2:0]] = ~buf_data[fbyte][fbit[2:0]];
            exp_st = 2'd1;
        end else if (mode == 2) begin
            stored_code[fbit] = ~stored_code[fbit];
            exp_st = 2'd2;
        end else if (mode == 3) begin
            buf_data[fbyte][fbit[2:0]] = ~buf_data[fbyte][fbit[2:0]];
            buf_data[fbyte ^ 8'h5A][fbit[2:0] ^ 3'd1] = ~buf_data[fbyte ^ 8'h5A][fbit[2:0] ^ 3'd1];
            exp_st = 2'd3;
        end
        fed = ref_code();
        stream(v[0]);
        chk(code_out == fed, "R3 R4 R5 code", code_out, fed);
        chk(res_valid == 1'b1, "R6 result strobe", res_valid, 1);
        chk(res_status == exp_st, (exp_st == 0) ? "R7 status" : (exp_st == 1) ? "R8 status" :
            (exp_st == 2) ? "R9 status" : "R10 status", res_status, exp_st);
        if (mode == 1) begin
            chk(err_byte == fbyte, "R8 byte offset", err_byte, fbyte);
            chk(err_bit == fbit[2:0], "R8 bit position", err_bit, fbit[2:0]);
        end else begin
            chk(err_byte == 0 && err_bit == 0, "R12 location zero", {err_byte, err_bit}, 0);
        end
        @(negedge clk);
        chk(res_valid == 1'b0, "R6 single cycle", res_valid, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [23:0] held;
        logic [23:0] exp_c;
        repeat (3) @(negedge clk);
        // R1 R5: reset state
        chk(res_valid == 1'b0, "R1 reset valid", res_valid, 0);
        chk(code_out == 24'hC00000, "R1 R5 reset code", code_out, 24'hC00000);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < 9; n++) run_vec(VEC[n]);

        // R11: bytes offered while idle are ignored
        held = code_out;
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1;
            in_byte  = 8'hFF;
            in_idx   = 8'(i * 37);
            @(negedge clk);
            chk(code_out == held, "R11 idle code hold", code_out, held);
            chk(res_valid == 1'b0, "R11 idle no result", res_valid, 0);
        end
        in_valid = 1'b0;

        // R2: restart partway through a chunk discards earlier bytes
        chunk_start = 1'b1;
        @(negedge clk);
        chunk_start = 1'b0;
        for (int i = 0; i < 40; i++) begin
            in_valid = 1'b1;
            in_byte  = 8'(i + 1);
            in_idx   = 8'(i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        fill(8'hC3);
        exp_c = ref_code();
        stored_code = exp_c;
        stream(1'b0);
        chk(code_out == exp_c, "R2 restart code", code_out, exp_c);
        chk(res_valid == 1'b1, "R2 R6 restart count", res_valid, 1);
        chk(res_status == 2'd0, "R2 R7 restart status", res_status, 0);
        @(negedge clk);

        // R4: single byte at index 0xA5 with odd parity sets alternating row bits
        chunk_start = 1'b1;
        @(negedge clk);
        chunk_start = 1'b0;
        in_valid = 1'b1;
        in_byte  = 8'h01;
        in_idx   = 8'hA5;
        @(negedge clk);
        in_valid = 1'b0;
        // idx 1010_0101: pairs pick odd member where bit set; bit 0 sets col even members
        chk(code_out == {2'b11, 6'b010101, 16'b10_01_10_01_01_10_01_10}, "R3 R4 single byte",
            code_out, {2'b11, 6'b010101, 16'b1001100101100110});

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule